// File: doc/BRIEF.md
# Multi-Mode Counter/Timer

This block is one byte-addressed counter/timer with a low byte and a high byte. A two-bit mode field arranges those bytes as a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself from the high byte, or two independent 8-bit counters. Software writes and reads every byte over a small single-cycle register bus. The bus has one shared address for reads and writes, and reads are combinational.

Each count step comes from one of two sources. The first is a timer tick: every system clock, or only the cycles in which an external prescaler asserts its tick enable. The second is a falling edge on an event pin, which is synchronised to the system clock. A rollover sets a sticky overflow flag. When the matching enable bit is set, that flag drives an interrupt request. The split two-counter arrangement is present only when the `SPLIT_EN` parameter is set. This lets one instance of a pair provide it while the other does not.

Top module: `multimode_timer`

## Requirements
- R1: After reset, all four registers read as zero and both interrupt outputs are low.
- R2: Mode 0 counts the 13-bit value {high byte, low byte bits 4..0}. Low byte bits 7..5 are neither changed by counting nor allowed to carry into the count. A step from 0x1FFF wraps to 0x0000 and sets the low overflow flag.
- R3: Mode 1 counts the 16-bit value {high, low}. A step from 0xFFFF wraps to 0x0000 and sets the low overflow flag.
- R4: In timer-source mode, control bit 3 = 1 gives one step per system clock. Control bit 3 = 0 gives a step only in cycles where `presc_tick` is high.
- R5: Mode 2 increments the low byte. A step from 0xFF loads the low byte from the high byte and sets the low overflow flag. The high byte is left unchanged.
- R6: Mode 3 with `SPLIT_EN`=1 splits the block into two counters. The low byte counts under run bit 4 and sets flag bit 0 at 0xFF->0x00. The high byte counts timer ticks under run bit 5 and sets flag bit 1 at 0xFF->0x00.
- R7: With control bit 2 = 1, the low counter steps once per falling edge of `ev_in`, after a two-flop synchronizer. Rising edges do not step it. A level held for at least two clocks is always seen.
- R8: When the run bits are clear, the counter bytes hold their values.
- R9: Overflow flags stay set until a status write loads them. Set wins over a same-cycle clear. `irq_main` = flag0 AND control bit 6, and `irq_aux` = flag1 AND control bit 7.
- R10: With `SPLIT_EN`=0, mode 3 freezes both counter bytes.
- R11: The register map is: address 0 low byte, 1 high byte, 2 control ([1:0] mode, [2] event source, [3] system-clock tick, [4] run low, [5] run high, [6] low irq enable, [7] high irq enable), 3 status ([0] low flag, [1] high flag). A write to the low or high byte takes priority and suppresses counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| presc_tick | input | 1 | Prescaled timer tick enable |
| ev_in | input | 1 | External event pin |
| irq_main | output | 1 | Interrupt request of the low counter |
| irq_aux | output | 1 | Interrupt request of the high split counter |

## Verification
The embedded assertions check several rules on every cycle:
- the masked low-byte bits stay untouched in 13-bit mode;
- both bytes hold while the run bits are clear;
- a flag stays set until a status write;
- mode 2 reloads from the high byte;
- the 13-bit wrap;
- the frozen split mode when `SPLIT_EN` is 0.

Exact step counts come only from the bench scenarios: counts under a gated prescaler tick, one step per falling event edge, the independence of the two split counters, and the bus-write priority.

// File: rtl/multimode_timer.sv
`timescale 1ns/1ps
module multimode_timer #(
  parameter bit SPLIT_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       presc_tick,
  input  logic       ev_in,
  output logic       irq_main,
  output logic       irq_aux
);
  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CTL = 2'd2, A_STS = 2'd3;

  logic [7:0] tl, th, ctl;
  logic       ovf_lo, ovf_hi;
  logic [2:0] ev_sync;

  wire [1:0] mode    = ctl[1:0];
  wire       ev_src  = ctl[2];
  wire       sys_sel = ctl[3];
  wire       run_lo  = ctl[4];
  wire       run_hi  = ctl[5];

  wire wr_lo  = wr_en && addr == A_LO;
  wire wr_hi  = wr_en && addr == A_HI;
  wire wr_ctl = wr_en && addr == A_CTL;
  wire wr_sts = wr_en && addr == A_STS;
  wire byte_wr = wr_lo | wr_hi;

  wire ev_fall  = ev_sync[2] & ~ev_sync[1];
  wire tmr_tick = sys_sel | presc_tick;
  wire src_tick = ev_src ? ev_fall : tmr_tick;
  wire split_on = SPLIT_EN && mode == 2'd3;
  wire frozen   = !SPLIT_EN && mode == 2'd3;

  wire step_lo = run_lo & src_tick & ~byte_wr & ~frozen;
  wire step_hi = split_on & run_hi & tmr_tick & ~byte_wr;

  wire [12:0] c13 = {th, tl[4:0]};
  wire [15:0] c16 = {th, tl};

  logic [7:0] tl_n, th_n;
  logic       set_lo, set_hi;

  always_comb begin
    tl_n = tl;
    th_n = th;
    set_lo = 1'b0;
    set_hi = 1'b0;
    if (step_lo) begin
      case (mode)
        2'd0: begin
          {th_n, tl_n[4:0]} = c13 + 13'd1;
          set_lo = &c13;
        end
        2'd1: begin
          {th_n, tl_n} = c16 + 16'd1;
          set_lo = &c16;
        end
        2'd2: begin
          tl_n = (&tl) ? th : tl + 8'd1;
          set_lo = &tl;
        end
        default: begin
          tl_n = tl + 8'd1;
          set_lo = &tl;
        end
      endcase
    end
    if (step_hi) begin
      th_n = th + 8'd1;
      set_hi = &th;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tl <= '0;
      th <= '0;
      ctl <= '0;
      ovf_lo <= 1'b0;
      ovf_hi <= 1'b0;
      ev_sync <= 3'b111;
    end else begin
      ev_sync <= {ev_sync[1:0], ev_in};
      tl <= wr_lo ? wr_data : tl_n;
      th <= wr_hi ? wr_data : th_n;
      if (wr_ctl) ctl <= wr_data;
      ovf_lo <= set_lo | (wr_sts ? wr_data[0] : ovf_lo);
      ovf_hi <= set_hi | (wr_sts ? wr_data[1] : ovf_hi);
    end
  end

  always_comb begin
    case (addr)
      A_LO:    rd_data = tl;
      A_HI:    rd_data = th;
      A_CTL:   rd_data = ctl;
      default: rd_data = {6'd0, ovf_hi, ovf_lo};
    endcase
  end

  assign irq_main = ovf_lo & ctl[6];
  assign irq_aux  = ovf_hi & ctl[7];

  AST_UPPER_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !wr_lo) |=> $stable(tl[7:5])); // R2
  AST_WRAP_13: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && step_lo && c13 == 13'h1FFF) |=> (ovf_lo && th == 8'h00 && tl[4:0] == 5'd0)); // R2
  AST_RELOAD_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && step_lo && tl == 8'hFF) |=> (tl == $past(th) && ovf_lo)); // R5
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_lo && !run_hi && !byte_wr) |=> ($stable(tl) && $stable(th))); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_lo && !wr_sts) |=> ovf_lo); // R9
  AST_SPLIT_ABSENT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !byte_wr) |=> ($stable(tl) && $stable(th))); // R10
endmodule

// File: tb/multimode_timer_bench.sv
`timescale 1ns/1ps
module multimode_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, presc_tick = 1'b0, ev_in = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0, rd_data, rd_data2;
  logic irq_main, irq_aux, irq_main2, irq_aux2;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { int sel; logic [7:0] exp; string tag; } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  multimode_timer u_multimode_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .presc_tick(presc_tick), .ev_in(ev_in),
    .irq_main(irq_main), .irq_aux(irq_aux));

  multimode_timer #(.SPLIT_EN(1'b0)) u_multimode_timer_nosplit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data2), .presc_tick(presc_tick), .ev_in(ev_in),
    .irq_main(irq_main2), .irq_aux(irq_aux2));

  initial forever begin
    @(negedge clk);
    #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sbq.pop_front();
      case (it.sel)
        0: act = rd_data;
        1: act = {7'd0, irq_main};
        2: act = {7'd0, irq_aux};
        default: act = rd_data2;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int sel, input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    addr = a;
    sbq.push_back('{sel, e, tag});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_cycles(input logic [7:0] run_v, input logic [7:0] stop_v, input int n);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd2; wr_data = run_v;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (n - 1) @(negedge clk);
    wr_en = 1'b1; wr_data = stop_v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) expect_val(0, 2'(a), 8'h00, "R1 reset register");
    expect_val(1, 2'd0, 8'h00, "R1 irq_main reset");
    expect_val(2, 2'd0, 8'h00, "R1 irq_aux reset");

    // R2 13-bit mode, start 0x1FFD with masked bits set
    wr(2'd2, 8'h48); wr(2'd0, 8'hFD); wr(2'd1, 8'hFF);
    run_cycles(8'h58, 8'h48, 2);
    expect_val(0, 2'd0, 8'hFF, "R2 low byte at 0x1FFF");
    expect_val(0, 2'd3, 8'h00, "R2 no flag before wrap");
    run_cycles(8'h58, 8'h48, 1);
    expect_val(0, 2'd0, 8'hE0, "R2 low byte after wrap keeps masked bits");
    expect_val(0, 2'd1, 8'h00, "R2 high byte after wrap");
    expect_val(0, 2'd3, 8'h01, "R2 flag on 13-bit wrap");
    expect_val(1, 2'd0, 8'h01, "R9 irq_main with enable");
    expect_val(0, 2'd2, 8'h48, "R11 control readback");

    // R9 sticky flag
    repeat (5) @(negedge clk);
    expect_val(0, 2'd3, 8'h01, "R9 flag held");
    wr(2'd3, 8'h00);
    expect_val(0, 2'd3, 8'h00, "R9 flag cleared by write");
    expect_val(1, 2'd0, 8'h00, "R9 irq_main cleared");

    // R3 16-bit mode
    wr(2'd2, 8'h49); wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
    run_cycles(8'h59, 8'h49, 1);
    expect_val(0, 2'd0, 8'hFF, "R3 low at 0xFFFF");
    expect_val(0, 2'd3, 8'h00, "R3 no flag before wrap");
    run_cycles(8'h59, 8'h49, 1);
    expect_val(0, 2'd0, 8'h00, "R3 low after wrap");
    expect_val(0, 2'd1, 8'h00, "R3 high after wrap");
    expect_val(0, 2'd3, 8'h01, "R3 flag on 16-bit wrap");
    wr(2'd3, 8'h00);

    // R4 prescaled tick gating
    wr(2'd2, 8'h41);
    presc_tick = 1'b0;
    run_cycles(8'h51, 8'h41, 5);
    expect_val(0, 2'd0, 8'h00, "R4 no step without tick");
    presc_tick = 1'b1;
    run_cycles(8'h51, 8'h41, 4);
    presc_tick = 1'b0;
    expect_val(0, 2'd0, 8'h04, "R4 step per tick");

    // R5 auto-reload
    wr(2'd2, 8'h4A); wr(2'd1, 8'h80); wr(2'd0, 8'hFE);
    run_cycles(8'h5A, 8'h4A, 4);
    expect_val(0, 2'd0, 8'h82, "R5 reload then count");
    expect_val(0, 2'd1, 8'h80, "R5 high byte unchanged");
    expect_val(0, 2'd3, 8'h01, "R5 flag on reload");
    repeat (10) @(negedge clk);
    expect_val(0, 2'd0, 8'h82, "R8 held while stopped");
    wr(2'd3, 8'h00);

    // R6 split mode, R10 absent split
    wr(2'd2, 8'hCB); wr(2'd0, 8'hFE); wr(2'd1, 8'hFD);
    run_cycles(8'hDB, 8'hCB, 2);
    expect_val(0, 2'd0, 8'h00, "R6 low counter wrapped");
    expect_val(0, 2'd1, 8'hFD, "R6 high counter idle");
    expect_val(0, 2'd3, 8'h01, "R6 low flag only");
    expect_val(1, 2'd0, 8'h01, "R6 irq_main");
    expect_val(2, 2'd0, 8'h00, "R6 irq_aux idle");
    expect_val(3, 2'd0, 8'hFE, "R10 frozen low");
    expect_val(3, 2'd3, 8'h00, "R10 no flag");
    run_cycles(8'hEB, 8'hCB, 3);
    expect_val(0, 2'd1, 8'h00, "R6 high counter wrapped");
    expect_val(0, 2'd0, 8'h00, "R6 low counter idle");
    expect_val(0, 2'd3, 8'h03, "R6 both flags");
    expect_val(2, 2'd0, 8'h01, "R9 irq_aux with enable");
    expect_val(3, 2'd1, 8'hFD, "R10 frozen high");
    wr(2'd3, 8'h00);
    expect_val(0, 2'd3, 8'h00, "R9 both flags cleared");

    // R7 event counting
    wr(2'd2, 8'h45); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'h55);
    for (int i = 0; i < 5; i++) begin
      ev_in = 1'b0; repeat (3) @(negedge clk);
      ev_in = 1'b1; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    wr(2'd2, 8'h45);
    expect_val(0, 2'd0, 8'h05, "R7 one step per falling edge");
    expect_val(0, 2'd1, 8'h00, "R7 high byte");

    // R11 write priority over counting
    wr(2'd2, 8'h49); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    @(negedge clk); wr_en = 1'b1; addr = 2'd2; wr_data = 8'h59;
    @(negedge clk); addr = 2'd0; wr_data = 8'h10;
    @(negedge clk); addr = 2'd2; wr_data = 8'h49;
    @(negedge clk); wr_en = 1'b0;
    expect_val(0, 2'd0, 8'h11, "R11 write wins then count resumes");
    expect_val(0, 2'd1, 8'h00, "R11 high byte");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule